// File: doc/BRIEF.md
# Interrupt Flag, Mask and Vector Unit

This block gathers six interrupt sources into sticky event flags, gates every flag with an enable bit of its own, and turns the result into one interrupt request line and a four-bit jump code. There are three timer taps, one remote-control event and two key-input groups. The timer and remote sources arrive as one-cycle pulses. The key groups arrive as active-low levels. A key flag sets on the edge where its input goes low while enabled. If the enable goes from 0 to 1 while the key is already held low, that also counts as such an edge.

Software reaches the unit through four nibble registers placed from a base address. Two registers hold the flags and clear them when they are read. The other two hold the enable bits and can be read and written. The jump code has one bit per source group and no priority between groups. The code is captured in the cycle in which the processor acknowledges the interrupt, and it is held until the next acknowledge. It supplies the low four bits of a handler address on a fixed page.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset every flag and every enable bit is 0, `irq_req_o` is 0, `vec_lo_o` is 0 and `reg_rdata_o` is 0.
- R2: A one-cycle pulse on `tick_i[i]` sets timer flag i, and a pulse on `rc_evt_i` sets the remote flag. Both set whatever the enable bits hold.
- R3: With `KEY_EDGE_ON_ENABLE`=1, key flag k sets only on the cycle in which the condition (`key_n_i[k]` low and its enable bit 1) becomes true. A key held low while its enable bit is 0 sets nothing.
- R4: If key k is held low and its enable bit is written from 0 to 1, the flag sets one cycle after the write. A flag that has been read and cleared while the key stays low and enabled does not set again.
- R5: The enable registers are read/write. At BASE+2, D0 is key 0, D1 is key 1 and D2 is remote. At BASE+3, D0 to D2 are timer taps 0 to 2. D3 always reads 0.
- R6: A read at BASE+0 (D0 key 0, D1 key 1, D2 remote) or BASE+1 (D0 to D2 timers 0 to 2) puts the flags on `reg_rdata_o` after the clock edge and clears those flags. Writes to the flag addresses change nothing.
- R7: If a source event arrives in the same cycle as the clearing read of its register, the read returns the old value and the flag stays set.
- R8: `irq_req_o` is 1 exactly when at least one flag is set and its enable bit is 1.
- R9: On `irq_ack_i` the unit captures a code into `vec_lo_o`. Bit 3 is any enabled timer flag, bit 2 the enabled remote flag, bit 1 enabled key 1 and bit 0 enabled key 0. A timer alone gives 8h, and a timer together with the remote source gives Ch. The code holds until the next acknowledge.
- R10: A flag whose enable bit is 0 does not reach `irq_req_o` or the code.
- R11: A read at an address outside BASE..BASE+3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | NUM_TIMER | Timer tap pulses, one per tap |
| rc_evt_i | input | 1 | Remote-control event pulse |
| key_n_i | input | 2 | Active-low key group levels |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 4 | Write data nibble |
| reg_rdata_o | output | 4 | Read data nibble, valid after the read edge |
| irq_req_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Processor acknowledge, captures the code |
| vec_lo_o | output | 4 | Low four bits of the handler address |

## Verification
The bench builds the unit with its defaults: an 8-bit address with a base of F0h, all three timer taps, and key detection that is gated by the enable bit. The gated variant is the one that makes the enable-rewrite case reachable. The bench holds a key low, clears its enable bit, sets it again and then watches the flag set for a second time. Having three taps lets it show that a timer bit in the code is an OR over the taps, and that a tap whose enable bit is 0 has no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int NIB_W      = 4;
   localparam int KEY_GROUPS = 2;
   localparam int TMR_SLOTS  = 3;

   typedef struct packed {
      logic [TMR_SLOTS-1:0]  tmr;
      logic                  rc;
      logic [KEY_GROUPS-1:0] key;
   } src_vec_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_FLAG_LO,
      SEL_FLAG_HI,
      SEL_MASK_LO,
      SEL_MASK_HI
   } reg_sel_e;

   function automatic logic [NIB_W-1:0] group_code(input src_vec_t f, input src_vec_t m);
      logic [NIB_W-1:0] c;
      c[3] = |(f.tmr & m.tmr);
      c[2] = f.rc & m.rc;
      c[1] = f.key[1] & m.key[1];
      c[0] = f.key[0] & m.key[0];
      return c;
   endfunction

endpackage

// File: rtl/irq_key_edge.sv
module irq_key_edge #(
   parameter bit EDGE_ON_ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n_i,
   input  logic en_i,
   output logic set_o
);

   logic live;
   logic live_q;

   generate
      if (EDGE_ON_ENABLE) begin : g_gated
         assign live = ~key_n_i & en_i;
      end else begin : g_raw
         logic en_unused;
         assign en_unused = en_i;
         assign live      = ~key_n_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= live;
   end

   assign set_o = live & ~live_q;

   // R3
   key_set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_o |-> !key_n_i);

   // R4
   key_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_o |=> !set_o);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);

   logic [W-1:0] flag_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign flag_o = flag_q;

   // R7
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_pkg::*;
#(
   parameter int             ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hF0,
   parameter int             NUM_TIMER = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [NIB_W-1:0]  wdata_i,
   input  src_vec_t          flags_i,
   output src_vec_t          mask_o,
   output src_vec_t          clr_o,
   output logic [NIB_W-1:0]  rdata_o
);

   localparam logic [ADDR_W-1:0] A_FLAG_LO = BASE_ADDR;
   localparam logic [ADDR_W-1:0] A_FLAG_HI = BASE_ADDR + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MASK_LO = BASE_ADDR + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_MASK_HI = BASE_ADDR + ADDR_W'(3);

   logic [TMR_SLOTS-1:0] tmr_valid;

   generate
      for (genvar i = 0; i < TMR_SLOTS; i++) begin : g_tvalid
         if (i < NUM_TIMER) begin : g_on
            assign tmr_valid[i] = 1'b1;
         end else begin : g_off
            assign tmr_valid[i] = 1'b0;
         end
      end
   endgenerate

   reg_sel_e sel;

   always_comb begin
      unique case (addr_i)
         A_FLAG_LO: sel = SEL_FLAG_LO;
         A_FLAG_HI: sel = SEL_FLAG_HI;
         A_MASK_LO: sel = SEL_MASK_LO;
         A_MASK_HI: sel = SEL_MASK_HI;
         default:   sel = SEL_NONE;
      endcase
   end

   logic [KEY_GROUPS-1:0] m_key_q;
   logic                  m_rc_q;
   logic [TMR_SLOTS-1:0]  m_tmr_q;
   logic                  wdata_spare_unused;

   assign wdata_spare_unused = wdata_i[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_key_q <= '0;
         m_rc_q  <= 1'b0;
         m_tmr_q <= '0;
      end else if (wr_i) begin
         if (sel == SEL_MASK_LO) begin
            m_key_q <= wdata_i[1:0];
            m_rc_q  <= wdata_i[2];
         end
         if (sel == SEL_MASK_HI) begin
            m_tmr_q <= wdata_i[2:0] & tmr_valid;
         end
      end
   end

   assign mask_o.key = m_key_q;
   assign mask_o.rc  = m_rc_q;
   assign mask_o.tmr = m_tmr_q;

   logic rd_flag_lo;
   logic rd_flag_hi;

   assign rd_flag_lo = rd_i && (sel == SEL_FLAG_LO);
   assign rd_flag_hi = rd_i && (sel == SEL_FLAG_HI);

   assign clr_o.key = {KEY_GROUPS{rd_flag_lo}};
   assign clr_o.rc  = rd_flag_lo;
   assign clr_o.tmr = {TMR_SLOTS{rd_flag_hi}};

   logic [NIB_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_FLAG_LO: rd_mux = {1'b0, flags_i.rc, flags_i.key};
         SEL_FLAG_HI: rd_mux = {1'b0, flags_i.tmr};
         SEL_MASK_LO: rd_mux = {1'b0, m_rc_q, m_key_q};
         SEL_MASK_HI: rd_mux = {1'b0, m_tmr_q};
         default:     rd_mux = '0;
      endcase
   end

   logic [NIB_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;

   // R5
   mask_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_MASK_HI) |=> (m_tmr_q == ($past(wdata_i[2:0]) & tmr_valid)));

   // R5
   rdata_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[3] == 1'b0);

   // R6
   flag_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (addr_i == A_FLAG_LO || addr_i == A_FLAG_HI)) |=> $stable(mask_o));

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irq_pkg::*;
#(
   parameter int                ADDR_W             = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR          = 8'hF0,
   parameter int                NUM_TIMER          = 3,
   parameter bit                KEY_EDGE_ON_ENABLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_TIMER-1:0]  tick_i,
   input  logic                  rc_evt_i,
   input  logic [KEY_GROUPS-1:0] key_n_i,
   input  logic [ADDR_W-1:0]     reg_addr_i,
   input  logic                  reg_wr_i,
   input  logic                  reg_rd_i,
   input  logic [NIB_W-1:0]      reg_wdata_i,
   output logic [NIB_W-1:0]      reg_rdata_o,
   output logic                  irq_req_o,
   input  logic                  irq_ack_i,
   output logic [NIB_W-1:0]      vec_lo_o
);

   localparam int FLAG_W = $bits(src_vec_t);

   generate
      if (NUM_TIMER < 1 || NUM_TIMER > TMR_SLOTS) begin : g_bad_timer
         $error("NUM_TIMER must lie between 1 and 3");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("BASE_ADDR must be aligned to four");
      end
   endgenerate

   src_vec_t set_v;
   src_vec_t flags;
   src_vec_t masks;
   src_vec_t clr_v;

   generate
      for (genvar i = 0; i < TMR_SLOTS; i++) begin : g_tick
         if (i < NUM_TIMER) begin : g_on
            assign set_v.tmr[i] = tick_i[i];
         end else begin : g_off
            assign set_v.tmr[i] = 1'b0;
         end
      end
      for (genvar k = 0; k < KEY_GROUPS; k++) begin : g_key
         irq_key_edge #(
            .EDGE_ON_ENABLE (KEY_EDGE_ON_ENABLE)
         ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_n_i (key_n_i[k]),
            .en_i    (masks.key[k]),
            .set_o   (set_v.key[k])
         );
      end
   endgenerate

   assign set_v.rc = rc_evt_i;

   irq_flag_bank #(
      .W (FLAG_W)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .flag_o (flags)
   );

   irq_regs #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NUM_TIMER (NUM_TIMER)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr_i),
      .wr_i    (reg_wr_i),
      .rd_i    (reg_rd_i),
      .wdata_i (reg_wdata_i),
      .flags_i (flags),
      .mask_o  (masks),
      .clr_o   (clr_v),
      .rdata_o (reg_rdata_o)
   );

   logic [NIB_W-1:0] live_code;
   logic [NIB_W-1:0] vec_q;

   assign live_code = group_code(flags, masks);
   assign irq_req_o = |(flags & masks);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vec_q <= '0;
      else if (irq_ack_i) vec_q <= live_code;
   end

   assign vec_lo_o = vec_q;

   // R9
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_ack_i |=> $stable(vec_lo_o));

   // R8
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !irq_req_o) |=> (vec_lo_o == '0));

   // R10
   masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masks == '0) |-> !irq_req_o);

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && reg_addr_i == BASE_ADDR && set_v.key == '0 && !rc_evt_i)
      |=> (flags.key == '0 && !flags.rc));

endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tick_i = '0;
   logic       rc_evt_i = 1'b0;
   logic [1:0] key_n_i = 2'b11;
   logic [7:0] reg_addr_i = '0;
   logic       reg_wr_i = 1'b0;
   logic       reg_rd_i = 1'b0;
   logic [3:0] reg_wdata_i = '0;
   logic [3:0] reg_rdata_o;
   logic       irq_req_o;
   logic       irq_ack_i = 1'b0;
   logic [3:0] vec_lo_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] got;

   always #4 clk = ~clk;

   irq_vector_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .rc_evt_i    (rc_evt_i),
      .key_n_i     (key_n_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wr_i    (reg_wr_i),
      .reg_rd_i    (reg_rd_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .irq_req_o   (irq_req_o),
      .irq_ack_i   (irq_ack_i),
      .vec_lo_o    (vec_lo_o)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] d);
      reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
      step();
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [3:0] d);
      reg_addr_i = a; reg_rd_i = 1'b1;
      step();
      d = reg_rdata_o;
      reg_rd_i = 1'b0;
   endtask

   task automatic pulse_tick(input logic [2:0] t, input logic r);
      tick_i = t; rc_evt_i = r;
      step();
      tick_i = '0; rc_evt_i = 1'b0;
   endtask

   task automatic ack();
      irq_ack_i = 1'b1;
      step();
      irq_ack_i = 1'b0;
   endtask

   task automatic flush();
      logic [3:0] d;
      rd(8'hF0, d);
      rd(8'hF1, d);
   endtask

   task automatic t_reset();
      check("R1 rdata", reg_rdata_o, 4'h0);
      check("R1 irq", {3'b0, irq_req_o}, 4'h0);
      check("R1 vec", vec_lo_o, 4'h0);
      for (int a = 0; a < 4; a++) begin
         rd(8'hF0 + 8'(a), got);
         check("R1 reg", got, 4'h0);
      end
   endtask

   task automatic t_masks();
      wr(8'hF2, 4'hF);
      rd(8'hF2, got);
      check("R5 mask lo", got, 4'h7);
      wr(8'hF3, 4'hD);
      rd(8'hF3, got);
      check("R5 mask hi", got, 4'h5);
      wr(8'hF1, 4'hF);
      rd(8'hF1, got);
      check("R6 flag write ignored", got, 4'h0);
      rd(8'hF3, got);
      check("R6 mask kept", got, 4'h5);
      wr(8'hF2, 4'h0);
      wr(8'hF3, 4'h0);
      rd(8'h10, got);
      check("R11 undecoded", got, 4'h0);
   endtask

   task automatic t_flags();
      pulse_tick(3'b010, 1'b1);
      check("R10 no irq", {3'b0, irq_req_o}, 4'h0);
      rd(8'hF1, got);
      check("R2 timer flag", got, 4'h2);
      rd(8'hF1, got);
      check("R6 timer cleared", got, 4'h0);
      rd(8'hF0, got);
      check("R2 rc flag", got, 4'h4);
      rd(8'hF0, got);
      check("R6 rc cleared", got, 4'h0);
   endtask

   task automatic t_vector();
      wr(8'hF3, 4'h1);
      pulse_tick(3'b001, 1'b0);
      check("R8 irq", {3'b0, irq_req_o}, 4'h1);
      ack();
      check("R9 timer alone", vec_lo_o, 4'h8);
      wr(8'hF2, 4'h4);
      pulse_tick(3'b000, 1'b1);
      ack();
      check("R9 timer and rc", vec_lo_o, 4'hC);
      step(); step();
      check("R9 held", vec_lo_o, 4'hC);
      flush();
      check("R8 irq drops", {3'b0, irq_req_o}, 4'h0);
      pulse_tick(3'b010, 1'b0);
      check("R10 unmasked tap", {3'b0, irq_req_o}, 4'h0);
      ack();
      check("R10 vec zero", vec_lo_o, 4'h0);
      flush();
      wr(8'hF2, 4'h0);
      wr(8'hF3, 4'h0);
   endtask

   task automatic t_key();
      wr(8'hF2, 4'h1);
      key_n_i[0] = 1'b0;
      step();
      check("R3 key irq", {3'b0, irq_req_o}, 4'h1);
      ack();
      check("R9 key code", vec_lo_o, 4'h1);
      rd(8'hF0, got);
      check("R3 key flag", got, 4'h1);
      step();
      rd(8'hF0, got);
      check("R4 no repeat", got, 4'h0);
      key_n_i[0] = 1'b1;
      wr(8'hF2, 4'h0);
   endtask

   task automatic t_rewrite();
      key_n_i[1] = 1'b0;
      step(); step();
      rd(8'hF0, got);
      check("R3 masked low", got, 4'h0);
      wr(8'hF2, 4'h2);
      step();
      rd(8'hF0, got);
      check("R4 mask rewrite", got, 4'h2);
      wr(8'hF2, 4'h0);
      wr(8'hF2, 4'h2);
      step();
      rd(8'hF0, got);
      check("R4 second rewrite", got, 4'h2);
      key_n_i[1] = 1'b1;
      wr(8'hF2, 4'h0);
      flush();
   endtask

   task automatic t_same_cycle();
      reg_addr_i = 8'hF1; reg_rd_i = 1'b1; tick_i = 3'b100;
      step();
      got = reg_rdata_o;
      reg_rd_i = 1'b0; tick_i = '0;
      check("R7 old value", got, 4'h0);
      rd(8'hF1, got);
      check("R7 flag kept", got, 4'h4);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_masks();
      t_flags();
      t_vector();
      t_key();
      t_rewrite();
      t_same_cycle();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule